// File: doc/BRIEF.md
# Dual-Clock FIFO with Read Rewind

This block is a first-in first-out buffer whose producer and consumer run on unrelated clocks. Words are stored in a dual-port memory indexed by a write counter and a read counter. Each counter crosses into the other clock domain in Gray code through a two-stage synchroniser. The write domain registers a full flag and a near-full flag. The read domain registers an empty flag and a near-empty flag. Both near thresholds are parameters.

One asynchronous, active-low reset clears both counters and all flags in both domains. A second control, `rewind`, is synchronous to the read clock. It returns only the read counter to the first memory location, so words that were already consumed can be read out a second time. This is useful for resending a packet whose delivery failed. A rewind is meaningful only while no more than the memory depth has been written since the last global reset.

Top module: `dcfifo_rewind`

## Requirements
- R1: While `grst_n` is low, and after it rises, `empty`=1, `aempty`=1, `full`=0, `afull`=0 and `rdata`=0. The next word written is the next word read.
- R2: Words are read out in the order they were written. `rdata` takes the new word on the read-clock edge that accepts a read (`rce`=1, `ren`=1, `empty`=0, `rewind`=0). At all other times `rdata` holds its value.
- R3: A write presented while `full`=1 is dropped. The write counter does not move, and no stored word is overwritten.
- R4: A read presented while `empty`=1 is dropped. The read counter does not move, and `rdata` holds its value.
- R5: The flags `full` and `afull` are registered on `wclk`. `full`=1 when the fill level seen by the write side is at least DEPTH=2^AW. `afull`=1 when that level is at least AF_LVL, where 1 ≤ AF_LVL ≤ DEPTH-1.
- R6: The flags `empty` and `aempty` are registered on `rclk`. `empty`=1 when the fill level seen by the read side is 0. `aempty`=1 when that level is at most AE_LVL, where 1 ≤ AE_LVL ≤ DEPTH-1.
- R7: A write needs both `wce` and `wen` high. A read needs both `rce` and `ren` high. With either signal low, nothing moves.
- R8: `rewind`=1 on a `rclk` edge sets the read counter to the first location. It takes priority over a read presented in the same cycle, which is dropped. The next accepted read returns the oldest word written since the global reset.
- R9: After a rewind, the write side recomputes its fill level from the rewound read counter, so `full` and `afull` can assert again.
- R10: Each counter crosses domains in Gray code. Outside a rewind, the Gray code changes by at most one bit per edge. Flags derived from the other domain are conservative: `empty` stays high for at least one read-clock edge after a write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| grst_n | input | 1 | Global asynchronous reset, active low, serving both domains |
| wclk | input | 1 | Write clock |
| wce | input | 1 | Write clock enable |
| wen | input | 1 | Write enable |
| wdata | input | DW | Word to store |
| full | output | 1 | Fill level has reached DEPTH (write domain) |
| afull | output | 1 | Fill level is at least AF_LVL (write domain) |
| rclk | input | 1 | Read clock |
| rce | input | 1 | Read clock enable |
| ren | input | 1 | Read enable |
| rewind | input | 1 | Return the read counter to the first location (read domain) |
| rdata | output | DW | Registered read word |
| empty | output | 1 | Fill level is zero (read domain) |
| aempty | output | 1 | Fill level is at most AE_LVL (read domain) |

## Verification
The assertions check the following on every edge:
- Writes while full and reads while empty leave their counters still.
- A write or read with an enable low does nothing.
- `rdata` holds unless a read is accepted.
- A rewind lands the read counter on zero.
- Each Gray counter steps by at most one bit.
- `full` implies `afull`, and `empty` implies `aempty`.

Only the bench scenarios can show the following:
- The words come out in the order written.
- The thresholds switch at the right fill levels.
- Rewound data is replayed exactly and re-raises `full`.
- A global reset in mid-stream restarts both counters together.

// File: rtl/fifo_rw_pkg.sv
package fifo_rw_pkg;

    // Binary to Gray code on a 32-bit carrier; callers truncate.
    function automatic logic [31:0] bin2gray(input logic [31:0] b);
        return b ^ (b >> 1);
    endfunction

    // Gray code to binary on a 32-bit carrier; upper zeros pass through.
    function automatic logic [31:0] gray2bin(input logic [31:0] g);
        logic [31:0] b;
        b[31] = g[31];
        for (int i = 30; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/fifo_sync2.sv
module fifo_sync2 #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d.s1 = d;
        s_d.s2 = s_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign q = s_q.s2;
endmodule

// File: rtl/fifo_mem.sv
module fifo_mem #(
    parameter int DW = 8,
    parameter int AW = 4
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_d, rdata_q;

    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_comb begin
        rdata_d = rdata_q;
        if (re) rdata_d = mem[raddr];
    end

    always_ff @(posedge rclk or negedge rst_n) begin
        if (!rst_n) rdata_q <= '0;
        else        rdata_q <= rdata_d;
    end

    assign rdata = rdata_q;

    AST_RDATA_HOLD: assert property (@(posedge rclk) disable iff (!rst_n)
        !re |=> $stable(rdata_q)); // R2
endmodule

// File: rtl/fifo_wr_ctl.sv
module fifo_wr_ctl
    import fifo_rw_pkg::*;
#(
    parameter int AW     = 4,
    parameter int AF_LVL = 12
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ce,
    input  logic        en,
    input  logic [AW:0] rgray_sync,
    output logic        fire,
    output logic [AW:0] bin,
    output logic [AW:0] gray,
    output logic        full,
    output logic        afull
);
    localparam int          PW    = AW + 1;
    localparam int          DEPTH = 1 << AW;
    localparam logic [AW:0] FULL_CNT = PW'(DEPTH);
    localparam logic [AW:0] AF_CNT   = PW'(AF_LVL);

    typedef struct packed {
        logic [AW:0] bin;
        logic [AW:0] gray;
        logic        full;
        logic        afull;
    } wst_t;

    wst_t        s_d, s_q;
    logic        fire_c;
    logic [AW:0] rbin_c, cnt_c;

    always_comb begin
        fire_c     = ce & en & ~s_q.full;
        s_d.bin    = s_q.bin + PW'(fire_c);
        s_d.gray   = PW'(bin2gray(32'(s_d.bin)));
        rbin_c     = PW'(gray2bin(32'(rgray_sync)));
        cnt_c      = s_d.bin - rbin_c;
        s_d.full   = (cnt_c >= FULL_CNT);
        s_d.afull  = (cnt_c >= AF_CNT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{bin: '0, gray: '0, full: 1'b0, afull: 1'b0};
        else        s_q <= s_d;
    end

    assign fire  = fire_c;
    assign bin   = s_q.bin;
    assign gray  = s_q.gray;
    assign full  = s_q.full;
    assign afull = s_q.afull;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.full && ce && en) |=> $stable(s_q.bin)); // R3
    AST_WR_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        !(ce && en) |=> $stable(s_q.bin)); // R7
    AST_AFULL_WITH_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.full |-> s_q.afull); // R5
    AST_WGRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(s_q.gray ^ $past(s_q.gray))); // R10
endmodule

// File: rtl/fifo_rd_ctl.sv
module fifo_rd_ctl
    import fifo_rw_pkg::*;
#(
    parameter int AW     = 4,
    parameter int AE_LVL = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ce,
    input  logic        en,
    input  logic        rewind,
    input  logic [AW:0] wgray_sync,
    output logic        fire,
    output logic [AW:0] bin,
    output logic [AW:0] gray,
    output logic        empty,
    output logic        aempty
);
    localparam int          PW     = AW + 1;
    localparam logic [AW:0] AE_CNT = PW'(AE_LVL);

    typedef struct packed {
        logic [AW:0] bin;
        logic [AW:0] gray;
        logic        empty;
        logic        aempty;
    } rst_t;

    rst_t        s_d, s_q;
    logic        fire_c;
    logic [AW:0] wbin_c, cnt_c;

    always_comb begin
        fire_c = ce & en & ~s_q.empty & ~rewind;
        if (rewind) s_d.bin = '0;
        else        s_d.bin = s_q.bin + PW'(fire_c);
        s_d.gray   = PW'(bin2gray(32'(s_d.bin)));
        wbin_c     = PW'(gray2bin(32'(wgray_sync)));
        cnt_c      = wbin_c - s_d.bin;
        s_d.empty  = (cnt_c == '0);
        s_d.aempty = (cnt_c <= AE_CNT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{bin: '0, gray: '0, empty: 1'b1, aempty: 1'b1};
        else        s_q <= s_d;
    end

    assign fire   = fire_c;
    assign bin    = s_q.bin;
    assign gray   = s_q.gray;
    assign empty  = s_q.empty;
    assign aempty = s_q.aempty;

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.empty && !rewind) |=> $stable(s_q.bin)); // R4
    AST_RD_NEEDS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!(ce && en) && !rewind) |=> $stable(s_q.bin)); // R7
    AST_REWIND_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        rewind |=> (s_q.bin == '0)); // R8
    AST_AEMPTY_WITH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.empty |-> s_q.aempty); // R6
    AST_RGRAY_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !rewind |=> $onehot0(s_q.gray ^ $past(s_q.gray))); // R10
endmodule

// File: rtl/dcfifo_rewind.sv
module dcfifo_rewind #(
    parameter int DW     = 8,
    parameter int AW     = 4,
    parameter int AF_LVL = 12,
    parameter int AE_LVL = 2
) (
    input  logic          grst_n,
    input  logic          wclk,
    input  logic          wce,
    input  logic          wen,
    input  logic [DW-1:0] wdata,
    output logic          full,
    output logic          afull,
    input  logic          rclk,
    input  logic          rce,
    input  logic          ren,
    input  logic          rewind,
    output logic [DW-1:0] rdata,
    output logic          empty,
    output logic          aempty
);
    localparam int PW = AW + 1;

    logic          wfire, rfire;
    logic [PW-1:0] wbin, wgray, rbin, rgray;
    logic [PW-1:0] wgray_in_r, rgray_in_w;

    fifo_wr_ctl #(.AW(AW), .AF_LVL(AF_LVL)) u_wr (
        .clk(wclk), .rst_n(grst_n), .ce(wce), .en(wen),
        .rgray_sync(rgray_in_w), .fire(wfire), .bin(wbin), .gray(wgray),
        .full(full), .afull(afull)
    );

    fifo_rd_ctl #(.AW(AW), .AE_LVL(AE_LVL)) u_rd (
        .clk(rclk), .rst_n(grst_n), .ce(rce), .en(ren), .rewind(rewind),
        .wgray_sync(wgray_in_r), .fire(rfire), .bin(rbin), .gray(rgray),
        .empty(empty), .aempty(aempty)
    );

    fifo_sync2 #(.W(PW)) u_w2r (
        .clk(rclk), .rst_n(grst_n), .d(wgray), .q(wgray_in_r)
    );

    fifo_sync2 #(.W(PW)) u_r2w (
        .clk(wclk), .rst_n(grst_n), .d(rgray), .q(rgray_in_w)
    );

    fifo_mem #(.DW(DW), .AW(AW)) u_mem (
        .wclk(wclk), .we(wfire), .waddr(wbin[AW-1:0]), .wdata(wdata),
        .rclk(rclk), .rst_n(grst_n), .re(rfire), .raddr(rbin[AW-1:0]),
        .rdata(rdata)
    );
endmodule

// File: tb/sim_dcfifo_rewind.sv
`timescale 1ns/1ps
module sim_dcfifo_rewind;
    localparam int DW = 8;
    localparam int AW = 2;   // depth 4
    localparam int NV = 19;

    logic          grst_n = 1'b0;
    logic          wclk = 1'b0, rclk = 1'b0;
    logic          wce = 1'b0, wen = 1'b0, rce = 1'b0, ren = 1'b0, rewind = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic          full, afull, empty, aempty;
    logic [DW-1:0] rdata;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #2 wclk = ~wclk;   // 250 MHz
    always #3 rclk = ~rclk;

    dcfifo_rewind #(.DW(DW), .AW(AW), .AF_LVL(3), .AE_LVL(1)) u0 (
        .grst_n(grst_n), .wclk(wclk), .wce(wce), .wen(wen), .wdata(wdata),
        .full(full), .afull(afull), .rclk(rclk), .rce(rce), .ren(ren),
        .rewind(rewind), .rdata(rdata), .empty(empty), .aempty(aempty)
    );

    // {op, wdata, expected rdata, req tag, {empty, aempty, full, afull}}
    // op: 0 write, 1 read, 2 write with wce low, 3 rewind, 4 read with rce low
    localparam logic [27:0] VEC [NV] = '{
        {4'd0, 8'h11, 8'h00, 4'd5, 4'b0100},
        {4'd0, 8'h22, 8'h00, 4'd5, 4'b0000},
        {4'd0, 8'h33, 8'h00, 4'd5, 4'b0001},
        {4'd0, 8'h44, 8'h00, 4'd5, 4'b0011},
        {4'd0, 8'h55, 8'h00, 4'd3, 4'b0011},
        {4'd1, 8'h00, 8'h11, 4'd2, 4'b0001},
        {4'd1, 8'h00, 8'h22, 4'd2, 4'b0000},
        {4'd2, 8'h66, 8'h22, 4'd7, 4'b0000},
        {4'd4, 8'h00, 8'h22, 4'd7, 4'b0000},
        {4'd1, 8'h00, 8'h33, 4'd6, 4'b0100},
        {4'd1, 8'h00, 8'h44, 4'd6, 4'b1100},
        {4'd1, 8'h00, 8'h44, 4'd4, 4'b1100},
        {4'd3, 8'h00, 8'h44, 4'd9, 4'b0011},
        {4'd1, 8'h00, 8'h11, 4'd8, 4'b0001},
        {4'd0, 8'h77, 8'h11, 4'd5, 4'b0011},
        {4'd1, 8'h00, 8'h22, 4'd2, 4'b0001},
        {4'd1, 8'h00, 8'h33, 4'd2, 4'b0000},
        {4'd1, 8'h00, 8'h44, 4'd6, 4'b0100},
        {4'd1, 8'h00, 8'h77, 4'd6, 4'b1100}
    };

    function automatic string tag(input logic [3:0] t);
        case (t)
            4'd2:    return "R2";
            4'd3:    return "R3";
            4'd4:    return "R4";
            4'd5:    return "R5";
            4'd6:    return "R6";
            4'd7:    return "R7";
            4'd8:    return "R8";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [DW-1:0] d, input logic ce);
        @(negedge wclk);
        wce = ce; wen = 1'b1; wdata = d;
        @(negedge wclk);
        wce = 1'b0; wen = 1'b0;
    endtask

    task automatic rd(input logic ce, input logic rw);
        @(negedge rclk);
        rce = ce; ren = 1'b1; rewind = rw;
        @(negedge rclk);
        rce = 1'b0; ren = 1'b0; rewind = 1'b0;
    endtask

    task automatic rwd();
        @(negedge rclk);
        rewind = 1'b1;
        @(negedge rclk);
        rewind = 1'b0;
    endtask

    task automatic settle();
        repeat (6) @(posedge rclk);
        repeat (6) @(posedge wclk);
        @(negedge wclk);
    endtask

    task automatic chk_flags(input string req, input logic [3:0] f);
        chk(req, "empty",  32'(empty),  32'(f[3]));
        chk(req, "aempty", 32'(aempty), 32'(f[2]));
        chk(req, "full",   32'(full),   32'(f[1]));
        chk(req, "afull",  32'(afull),  32'(f[0]));
    endtask

    task automatic do_reset();
        #1 grst_n = 1'b0;
        #17 grst_n = 1'b1;
        settle();
    endtask

    initial begin
        // R1: reset state
        #9;
        chk("R1", "empty in reset",  32'(empty),  32'd1);
        chk("R1", "aempty in reset", 32'(aempty), 32'd1);
        chk("R1", "full in reset",   32'(full),   32'd0);
        chk("R1", "afull in reset",  32'(afull),  32'd0);
        chk("R1", "rdata in reset",  32'(rdata),  32'd0);
        #9 grst_n = 1'b1;
        settle();
        chk_flags("R1", 4'b1100);

        // Vector walk
        for (int i = 0; i < NV; i++) begin
            logic [27:0] v;
            v = VEC[i];
            case (v[27:24])
                4'd0:    wr(v[23:16], 1'b1);
                4'd1:    rd(1'b1, 1'b0);
                4'd2:    wr(v[23:16], 1'b0);
                4'd3:    rwd();
                default: rd(1'b0, 1'b0);
            endcase
            settle();
            chk(tag(v[7:4]), $sformatf("vec %0d rdata", i), 32'(rdata), 32'(v[15:8]));
            chk_flags(tag(v[7:4]), v[3:0]);
        end

        // R1: global reset in mid-stream restarts both counters
        wr(8'hC1, 1'b1);
        wr(8'hC2, 1'b1);
        settle();
        do_reset();
        chk_flags("R1", 4'b1100);
        chk("R1", "rdata after mid reset", 32'(rdata), 32'd0);
        wr(8'hA5, 1'b1);
        settle();
        rd(1'b1, 1'b0);
        settle();
        chk("R1", "first word after reset", 32'(rdata), 32'hA5);
        chk_flags("R1", 4'b1100);

        // R8: rewind wins over a read in the same cycle
        do_reset();
        wr(8'h01, 1'b1);
        wr(8'h02, 1'b1);
        settle();
        rd(1'b1, 1'b0);
        settle();
        chk("R2", "first of pair", 32'(rdata), 32'h01);
        rd(1'b1, 1'b1);
        settle();
        chk("R8", "rdata held on rewind+read", 32'(rdata), 32'h01);
        rd(1'b1, 1'b0);
        settle();
        chk("R8", "replay starts at oldest", 32'(rdata), 32'h01);
        rd(1'b1, 1'b0);
        settle();
        chk("R8", "replay second word", 32'(rdata), 32'h02);
        chk_flags("R8", 4'b1100);

        // R10: empty stays high just after a write
        do_reset();
        @(negedge wclk);
        wce = 1'b1; wen = 1'b1; wdata = 8'h5A;
        @(posedge wclk);
        #0.5 wce = 1'b0; wen = 1'b0;
        @(posedge rclk);
        #0.5;
        chk("R10", "empty one rclk after write", 32'(empty), 32'd1);
        settle();
        chk("R10", "empty after sync delay", 32'(empty), 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge wclk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: run did not finish actual=hung expected=done");
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule